// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked shift mode of an 8-bit serial port. A single data line carries traffic in one direction at a time, and the block itself generates the shift clock that the far end uses. A write to the transmit buffer sends one byte, least significant bit first. Reception is started by clearing the receive-done flag while reception is enabled. The block then produces eight clock pulses and samples the incoming line once per pulse.

Every bit takes twelve system clocks. The shift clock idles high. It goes low for six clocks in the middle of each bit period and rises ten clocks after the bit period begins. Outgoing data therefore has ten clocks of setup before the rising edge and two clocks of hold after it. Incoming data is captured at the rising edge. Two sticky flags report the end of each transfer: one for transmit and one for receive. The received byte is presented on a parallel output.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data line is not driven (`ser_doe` low, `ser_dout` high), both done flags are 0 and `rx_data` is 0.
- R2: A buffer write while idle starts transmission. Bit b of the written byte (b = 0 first) is driven on `ser_dout` with `ser_doe` high for the 12 clocks that start 12·b+1 clocks after the write edge.
- R3: Within each 12-clock bit period (phase 0..11, where phase 0 is the first clock of the bit), `shift_clk` is low in phases 4..9 and high in every other phase. Its rising edge therefore comes 10 clocks after the data changes, and the data holds for 2 clocks after it.
- R4: `tx_done` goes to 1 and `ser_doe` falls 96 clocks after the write edge. A `tx_flag_clr` pulse clears `tx_done`. If the clear coincides with the completion, the completion wins.
- R5: A `rx_flag_clr` pulse while idle with `rx_enable` high clears `rx_done` and starts reception. The line is never driven during reception. `ser_din` is sampled on the clock edge at which `shift_clk` rises, bit 0 first. 96 clocks after the start edge, `rx_done` is 1 and `rx_data` holds the byte.
- R6: A `rx_flag_clr` pulse with `rx_enable` low clears `rx_done` but starts no transfer: the shift clock stays high and `rx_data` is unchanged.
- R7: A buffer write or a receive start request that arrives during a transfer has no effect on that transfer. A flag clear in that cycle still takes effect.
- R8: When a buffer write and a receive start request fall in the same idle cycle, transmission starts, no reception starts, `rx_done` is cleared and `rx_data` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Byte written to the transmit buffer |
| rx_enable | input | 1 | Allows a flag clear to start reception |
| rx_flag_clr | input | 1 | Clears `rx_done`; starts reception when permitted |
| tx_flag_clr | input | 1 | Clears `tx_done` |
| ser_din | input | 1 | Data line input |
| ser_dout | output | 1 | Data line output value |
| ser_doe | output | 1 | Data line output enable |
| shift_clk | output | 1 | Shift clock to the far end |
| tx_done | output | 1 | Sticky transmit-complete flag |
| rx_done | output | 1 | Sticky receive-complete flag |
| rx_data | output | 8 | Last received byte |

## Verification
Two pairs of events can land in the same cycle. The first pair is a transmit start and a reception start. The bench raises `buf_wr` and `rx_flag_clr` on the same idle edge with `rx_enable` high and `rx_done` set. It then checks that the full transmit waveform appears, that the line stays driven throughout, that `rx_done` reads 0 and that `rx_data` keeps its earlier byte. The second pair is a completion and a flag clear. The bench holds `tx_flag_clr` on the completion edge and requires `tx_done` to read 1 afterwards.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_TX   = 2'd1,
        XF_RX   = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/sync_shift_timer.sv
// Bit-period sequencer: phase counter within a bit and bit counter within a byte.
module sync_shift_timer #(
    parameter int BIT_CLKS   = 12,
    parameter int SETUP_CLKS = 10,
    parameter int NBITS      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic sample_stb,
    output logic bit_end,
    output logic last_end,
    output logic sclk_low
);
    localparam int PH_W      = $clog2(BIT_CLKS);
    localparam int BIT_W     = $clog2(NBITS);
    localparam int LOW_FIRST = SETUP_CLKS - BIT_CLKS / 2;
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(BIT_CLKS - 1);
    localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(SETUP_CLKS - 1);
    localparam logic [PH_W-1:0]  PH_LOW    = PH_W'(LOW_FIRST);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(NBITS - 1);

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [BIT_W-1:0] bitn;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d = '0;
        end else if (run) begin
            if (tmr_q.phase == PH_LAST) begin
                tmr_d.phase = '0;
                tmr_d.bitn  = tmr_q.bitn + 1'b1;
            end else begin
                tmr_d.phase = tmr_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign sample_stb = run && (tmr_q.phase == PH_SAMPLE);
    assign bit_end    = run && (tmr_q.phase == PH_LAST);
    assign last_end   = bit_end && (tmr_q.bitn == BIT_LAST);
    assign sclk_low   = run && (tmr_q.phase >= PH_LOW) && (tmr_q.phase <= PH_SAMPLE);

endmodule

// File: rtl/sync_shift_reg.sv
// Shared shift register, LSB leaves first, new bits enter at the MSB.
module sync_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = load_val;
        else if (shift) sh_d = {shift_in, sh_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;

endmodule

// File: rtl/sync_shift_ctrl.sv
// Transfer mode, start arbitration and sticky done flags.
module sync_shift_ctrl
    import sync_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_wr,
    input  logic         rx_enable,
    input  logic         rx_flag_clr,
    input  logic         tx_flag_clr,
    input  logic         last_end,
    input  logic [W-1:0] shift_val,
    output logic         start,
    output logic         load_tx,
    output xfer_mode_e   mode,
    output logic         tx_flag,
    output logic         rx_flag,
    output logic [W-1:0] rx_buf
);
    typedef struct packed {
        xfer_mode_e   mode;
        logic         tx_flag;
        logic         rx_flag;
        logic [W-1:0] rx_buf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        start   = 1'b0;
        load_tx = 1'b0;
        // Clears first so that a completion in the same cycle wins.
        if (tx_flag_clr) ctl_d.tx_flag = 1'b0;
        if (rx_flag_clr) ctl_d.rx_flag = 1'b0;
        if (ctl_q.mode == XF_IDLE) begin
            if (buf_wr) begin
                ctl_d.mode = XF_TX;
                start      = 1'b1;
                load_tx    = 1'b1;
            end else if (rx_flag_clr && rx_enable) begin
                ctl_d.mode = XF_RX;
                start      = 1'b1;
            end
        end else if (last_end) begin
            if (ctl_q.mode == XF_TX) begin
                ctl_d.tx_flag = 1'b1;
            end else begin
                ctl_d.rx_flag = 1'b1;
                ctl_d.rx_buf  = shift_val;
            end
            ctl_d.mode = XF_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mode    <= XF_IDLE;
            ctl_q.tx_flag <= 1'b0;
            ctl_q.rx_flag <= 1'b0;
            ctl_q.rx_buf  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode    = ctl_q.mode;
    assign tx_flag = ctl_q.tx_flag;
    assign rx_flag = ctl_q.rx_flag;
    assign rx_buf  = ctl_q.rx_buf;

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import sync_shift_pkg::*;
#(
    parameter int W          = 8,
    parameter int BIT_CLKS   = 12,
    parameter int SETUP_CLKS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_wdata,
    input  logic         rx_enable,
    input  logic         rx_flag_clr,
    input  logic         tx_flag_clr,
    input  logic         ser_din,
    output logic         ser_dout,
    output logic         ser_doe,
    output logic         shift_clk,
    output logic         tx_done,
    output logic         rx_done,
    output logic [W-1:0] rx_data
);
    xfer_mode_e   mode;
    logic         start, load_tx;
    logic         sample_stb, bit_end, last_end, sclk_low;
    logic         run, tx_active, rx_active;
    logic         shift, shift_in;
    logic [W-1:0] sh_val;

    assign run       = (mode != XF_IDLE);
    assign tx_active = (mode == XF_TX);
    assign rx_active = (mode == XF_RX);
    assign shift     = (tx_active && bit_end) || (rx_active && sample_stb);
    assign shift_in  = rx_active ? ser_din : 1'b1;

    sync_shift_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_wr      (buf_wr),
        .rx_enable   (rx_enable),
        .rx_flag_clr (rx_flag_clr),
        .tx_flag_clr (tx_flag_clr),
        .last_end    (last_end),
        .shift_val   (sh_val),
        .start       (start),
        .load_tx     (load_tx),
        .mode        (mode),
        .tx_flag     (tx_done),
        .rx_flag     (rx_done),
        .rx_buf      (rx_data)
    );

    sync_shift_timer #(
        .BIT_CLKS   (BIT_CLKS),
        .SETUP_CLKS (SETUP_CLKS),
        .NBITS      (W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (run),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .last_end   (last_end),
        .sclk_low   (sclk_low)
    );

    sync_shift_reg #(.W(W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_tx),
        .load_val (buf_wdata),
        .shift    (shift),
        .shift_in (shift_in),
        .q        (sh_val)
    );

    assign shift_clk = !sclk_low;
    assign ser_doe   = tx_active;
    assign ser_dout  = tx_active ? sh_val[0] : 1'b1;

endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk #(
    parameter int SETUP_CLKS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic shift_clk,
    input logic ser_dout,
    input logic ser_doe,
    input logic tx_done,
    input logic rx_done,
    input logic rx_active
);
    logic [7:0] since_chg_q;
    logic       last_oe_q, last_dat_q;

    // Clocks elapsed since the driven data last changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_chg_q <= '0;
            last_oe_q   <= 1'b0;
            last_dat_q  <= 1'b1;
        end else begin
            last_oe_q  <= ser_doe;
            last_dat_q <= ser_dout;
            if (ser_doe && (!last_oe_q || ser_dout != last_dat_q))
                since_chg_q <= 8'd1;
            else if (since_chg_q != 8'hFF)
                since_chg_q <= since_chg_q + 8'd1;
        end
    end

    // R3: data settled for the full setup window before the clock rises
    assert_setup_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shift_clk) && ser_doe) |-> (since_chg_q >= 8'(SETUP_CLKS)));

    // R3: data changes only after the clock has been high for two clocks
    assert_hold_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_doe && $past(ser_doe) && !$stable(ser_dout))
            |-> (shift_clk && $past(shift_clk) && $past(shift_clk, 2)));

    // R4: transmit flag rises exactly when the line is released
    assert_tx_flag_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(ser_doe) && !ser_doe));

    // R5: receive flag rises only when a reception ends
    assert_rx_flag_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ($past(rx_active) && !rx_active));

    // R5: the line is never driven during reception
    assert_rx_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> !ser_doe);

    // R7: transmission never begins straight out of a reception
    assert_no_tx_from_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_doe) |-> !$past(rx_active));

endmodule

bind sync_shift_port sync_shift_port_chk #(.SETUP_CLKS(SETUP_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_clk (shift_clk),
    .ser_dout  (ser_dout),
    .ser_doe   (ser_doe),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .rx_active (rx_active)
);

// File: tb/sync_shift_port_bench.sv
`timescale 1ns/1ps
module sync_shift_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       rx_enable = 1'b1;
    logic       rx_flag_clr = 1'b0;
    logic       tx_flag_clr = 1'b0;
    logic       ser_din = 1'b1;
    logic       ser_dout, ser_doe, shift_clk, tx_done, rx_done;
    logic [7:0] rx_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] last_rx = 8'h00;

    always #2 clk = ~clk;

    sync_shift_port u_sync_shift_port (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .rx_enable(rx_enable), .rx_flag_clr(rx_flag_clr), .tx_flag_clr(tx_flag_clr),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
        .shift_clk(shift_clk), .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data)
    );

    typedef struct packed { logic is_rx; logic [7:0] val; } vec_t;
    localparam vec_t VECS [6] = '{
        '{1'b0, 8'hA5}, '{1'b1, 8'h3C}, '{1'b0, 8'h00},
        '{1'b1, 8'hFF}, '{1'b0, 8'h81}, '{1'b1, 8'h96}
    };

    task automatic check(input string req, input bit ok,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_sclk(input int i);
        int ph = i % 12;
        return !(ph >= 4 && ph <= 9);
    endfunction

    // Transmit one byte; coll = receive request on the same edge,
    // poke = write + receive request mid-transfer, clr_end = clear on completion edge.
    task automatic run_tx(input logic [7:0] d, input bit coll, input bit poke,
                          input bit clr_end, input string tag);
        int bad = 0;
        @(negedge clk);
        buf_wr = 1'b1; buf_wdata = d; tx_flag_clr = 1'b1;
        if (coll) rx_flag_clr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0; tx_flag_clr = 1'b0; rx_flag_clr = 1'b0;
        for (int i = 0; i < 96; i++) begin
            if (shift_clk !== exp_sclk(i) || ser_dout !== d[i/12] ||
                ser_doe !== 1'b1 || tx_done !== 1'b0) bad++;
            if (poke && i == 30) begin buf_wr = 1'b1; buf_wdata = ~d; rx_flag_clr = 1'b1; end
            if (poke && i == 31) begin buf_wr = 1'b0; rx_flag_clr = 1'b0; end
            if (clr_end && i == 95) tx_flag_clr = 1'b1;
            @(negedge clk);
        end
        tx_flag_clr = 1'b0;
        check({tag, " R2 R3 tx waveform mismatches"}, bad == 0, bad, 0);
        check({tag, " R4 tx_done/doe/sclk after 96 clocks"},
              tx_done === 1'b1 && ser_doe === 1'b0 && shift_clk === 1'b1,
              {tx_done, ser_doe, shift_clk}, 3'b101);
    endtask

    task automatic run_rx(input logic [7:0] d, input string tag);
        int bad = 0;
        @(negedge clk);
        rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        for (int i = 0; i < 96; i++) begin
            ser_din = d[i/12];
            if (shift_clk !== exp_sclk(i) || ser_doe !== 1'b0 || rx_done !== 1'b0) bad++;
            @(negedge clk);
        end
        ser_din = 1'b1;
        check({tag, " R5 R3 rx waveform mismatches"}, bad == 0, bad, 0);
        check({tag, " R5 rx_done and rx_data"}, rx_done === 1'b1 && rx_data === d,
              {rx_done, rx_data}, {1'b1, d});
        last_rx = d;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog all R: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", shift_clk === 1'b1 && ser_doe === 1'b0 && ser_dout === 1'b1 &&
              tx_done === 1'b0 && rx_done === 1'b0 && rx_data === 8'h00,
              {shift_clk, ser_doe, ser_dout, tx_done, rx_done, rx_data},
              {5'b10100, 8'h00});

        // Table of transfers
        foreach (VECS[k]) begin
            if (VECS[k].is_rx) run_rx(VECS[k].val, "vec");
            else               run_tx(VECS[k].val, 1'b0, 1'b0, 1'b0, "vec");
        end

        // R4: clear of transmit flag
        @(negedge clk); tx_flag_clr = 1'b1;
        @(negedge clk); tx_flag_clr = 1'b0;
        check("R4 tx_flag_clr clears", tx_done === 1'b0, tx_done, 0);

        // R4: completion wins over a clear on the same edge
        run_tx(8'h5A, 1'b0, 1'b0, 1'b1, "R4 set-wins");

        // R7: write and receive request mid-transfer are ignored
        run_tx(8'hC3, 1'b0, 1'b1, 1'b0, "R7 mid-transfer");
        check("R7 rx_data kept after ignored request", rx_data === last_rx, rx_data, last_rx);

        // R6: clear with reception disabled starts nothing
        begin
            int bad = 0;
            rx_enable = 1'b0;
            @(negedge clk); rx_flag_clr = 1'b1;
            @(negedge clk); rx_flag_clr = 1'b0;
            for (int i = 0; i < 30; i++) begin
                if (shift_clk !== 1'b1 || ser_doe !== 1'b0) bad++;
                @(negedge clk);
            end
            check("R6 no activity with rx disabled", bad == 0, bad, 0);
            check("R6 rx_done cleared, rx_data kept", rx_done === 1'b0 && rx_data === last_rx,
                  {rx_done, rx_data}, {1'b0, last_rx});
            rx_enable = 1'b1;
        end

        // R8: transmit and receive requests on the same idle edge
        run_rx(8'h6B, "R8 prep");
        run_tx(8'h2D, 1'b1, 1'b0, 1'b0, "R8 collision");
        check("R8 rx_done cleared, rx_data kept", rx_done === 1'b0 && rx_data === 8'h6B,
              {rx_done, rx_data}, {1'b0, 8'h6B});

        summary();
        $finish;
    end
endmodule